// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder with Brightness Control

This block turns a 4-bit binary-coded decimal digit into active-high drive for the seven segments of a numeric display. A hold input freezes the digit: while it is low the incoming code goes straight to the decoder, and while it is high the decoder keeps showing the last code taken in. Codes above nine are not digits, so they blank the display.

Two active-low overrides sit in front of the decoder. The lamp-test input lights every segment. The blanking input darkens every segment. Lamp test wins over blanking, and blanking wins over the decoded digit.

Brightness is set by a built-in pulse-width generator. A free-running counter is compared with a programmable duty value, and while the counter is at or above the duty value the display is blanked. Everything runs on one clock, and the segment outputs are registered.

Top module: `seg7_latch_decoder`

## Requirements
- R1: While `lamp_test_n` is 0, the next clock drives `seg` to 7'b1111111. This holds whatever the values of `blank_n`, `hold`, `bcd_in` and the brightness generator.
- R2: While `lamp_test_n` is 1 and `blank_n` is 0, the next clock drives `seg` to 7'b0000000.
- R3: While `hold` is 0, the code shown is `bcd_in` and that code is stored on the clock edge. While `hold` is 1, the stored code is shown and kept, and changes on `bcd_in` have no effect.
- R4: Codes 10 to 15 drive all segments to 0.
- R5: The digits 0 to 9 map to `seg` as follows, with `seg[6]`=a down to `seg[0]`=g: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111 (segment a off), 7=1110000, 8=1111111, 9=1110011 (segment d off).
- R6: `seg` is registered. A change on any input shows on `seg` after exactly one rising clock edge.
- R7: While `rst_n` is 0, `seg` is 0, the stored code is 0, the duty value is all ones and the brightness counter is 0.
- R8: The brightness counter counts up by one on every clock and wraps at its width. When `duty_we` is 1, `duty_val` is loaded on that edge. Apart from the all-ones case, the display is lit only while the counter is below the duty value, so in any 256 consecutive clocks exactly `duty` of them are lit.
- R9: A duty value of 255 (all ones) gives full brightness with no dark cycles. A duty value of 0 keeps the display dark unless lamp test is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lamp_test_n | input | 1 | Lights all segments when 0 |
| blank_n | input | 1 | Darkens all segments when 0 |
| hold | input | 1 | 1 keeps the stored code, 0 passes and stores `bcd_in` |
| bcd_in | input | 4 | Digit code |
| duty_we | input | 1 | Loads `duty_val` into the duty register |
| duty_val | input | PWM_W | New brightness duty value |
| seg | output | 7 | Segment drive; `seg[6]`=a through `seg[0]`=g |

## Verification
The bench goes after three kinds of error.

The first is override order. A design that ranked blanking or dimming above lamp test would show a dark display while lamp test was held low with blanking also low.

The second is hold timing. A design that updated the stored code while `hold` was high, or missed the last code seen before `hold` rose, would show the newer digit instead of the frozen one.

The third is the edges of the brightness generator. The bench counts lit cycles over a full counter period at duty values of 0, 64 and 255. An off-by-one compare, or a missing full-brightness case, would give 1, 63, 65 or 255 lit cycles instead of 0, 64 and 256.

The bench also compares the two tail-less digits, 6 and 9, and every non-decimal code against its expected pattern.

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lamp_test_n,
  input  logic             blank_n,
  input  logic             hold,
  input  logic [3:0]       bcd_in,
  input  logic             duty_we,
  input  logic [PWM_W-1:0] duty_val,
  output logic [6:0]       seg
);
  localparam logic [PWM_W-1:0] DUTY_FULL = '1;

  logic [3:0]       code_q;
  logic [PWM_W-1:0] duty_q;
  logic [PWM_W-1:0] pwm_cnt;
  logic [6:0]       seg_q;
  logic [3:0]       shown;
  logic             lit;
  logic [6:0]       pattern;
  logic [6:0]       seg_d;

  assign shown = hold ? code_q : bcd_in;
  assign lit   = (duty_q == DUTY_FULL) || (pwm_cnt < duty_q);

  always_comb begin
    case (shown)
      4'd0:    pattern = 7'b1111110;
      4'd1:    pattern = 7'b0110000;
      4'd2:    pattern = 7'b1101101;
      4'd3:    pattern = 7'b1111001;
      4'd4:    pattern = 7'b0110011;
      4'd5:    pattern = 7'b1011011;
      4'd6:    pattern = 7'b0011111;
      4'd7:    pattern = 7'b1110000;
      4'd8:    pattern = 7'b1111111;
      4'd9:    pattern = 7'b1110011;
      default: pattern = 7'b0000000;
    endcase
  end

  assign seg_d = !lamp_test_n     ? 7'b1111111 :
                 (!blank_n || !lit) ? 7'b0000000 : pattern;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= 4'd0;
      duty_q  <= DUTY_FULL;
      pwm_cnt <= '0;
      seg_q   <= 7'b0000000;
    end else begin
      if (!hold)  code_q <= bcd_in;
      if (duty_we) duty_q <= duty_val;
      pwm_cnt <= pwm_cnt + 1'b1;
      seg_q   <= seg_d;
    end
  end

  assign seg = seg_q;
endmodule

module seg7_latch_decoder_chk #(
  parameter int PWM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lamp_test_n,
  input logic             blank_n,
  input logic             hold,
  input logic [3:0]       bcd_in,
  input logic [3:0]       code_q,
  input logic [PWM_W-1:0] duty_q,
  input logic [6:0]       seg
);
  localparam logic [PWM_W-1:0] DUTY_FULL = '1;

  p_lamp_test_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_test_n |=> seg == 7'b1111111);

  p_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test_n && !blank_n |=> seg == 7'b0000000);

  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(code_q));

  p_illegal_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test_n && !hold && bcd_in > 4'd9 |=> seg == 7'b0000000);

  p_dark_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test_n && duty_q == '0 |=> seg == 7'b0000000);

  p_full_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test_n && blank_n && !hold && bcd_in == 4'd8 && duty_q == DUTY_FULL
    |=> seg == 7'b1111111);

  always_comb if (!rst_n) p_reset_dark_r7: assert (seg == 7'b0000000);
endmodule

bind seg7_latch_decoder seg7_latch_decoder_chk #(.PWM_W(PWM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lamp_test_n(lamp_test_n), .blank_n(blank_n),
  .hold(hold), .bcd_in(bcd_in), .code_q(code_q), .duty_q(duty_q), .seg(seg)
);

// File: tb/seg7_latch_decoder_tb_top.sv
`timescale 1ns/1ps
module seg7_latch_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lamp_test_n = 1'b1;
  logic       blank_n = 1'b1;
  logic       hold = 1'b0;
  logic [3:0] bcd_in = 4'd0;
  logic       duty_we = 1'b0;
  logic [7:0] duty_val = 8'd0;
  logic [6:0] seg;

  int checks = 0;
  int bad = 0;
  string cur_req = "R7";
  bit finished = 0;

  int code_m, duty_m, cnt_m;
  logic [6:0] exp_seg = 7'b0;

  always #5 clk = ~clk;

  seg7_latch_decoder #(.PWM_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .lamp_test_n(lamp_test_n), .blank_n(blank_n),
    .hold(hold), .bcd_in(bcd_in), .duty_we(duty_we), .duty_val(duty_val),
    .seg(seg)
  );

  function automatic logic [6:0] digit_shape(int c);
    case (c)
      0: return 7'b1111110;  1: return 7'b0110000;
      2: return 7'b1101101;  3: return 7'b1111001;
      4: return 7'b0110011;  5: return 7'b1011011;
      6: return 7'b0011111;  7: return 7'b1110000;
      8: return 7'b1111111;  9: return 7'b1110011;
      default: return 7'b0000000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_m = 0; duty_m = 255; cnt_m = 0; exp_seg <= 7'b0;
    end else begin
      int shown;
      bit on;
      shown = hold ? code_m : int'(bcd_in);
      on = (duty_m == 255) || (cnt_m < duty_m);
      if (!lamp_test_n) exp_seg <= 7'b1111111;
      else if (!blank_n || !on) exp_seg <= 7'b0000000;
      else exp_seg <= digit_shape(shown);
      if (!hold) code_m = int'(bcd_in);
      if (duty_we) duty_m = int'(duty_val);
      cnt_m = (cnt_m + 1) % 256;
    end
  end

  task automatic check(string req, logic [6:0] act, logic [6:0] expv);
    checks++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: seg=%b expected=%b at %0t", req, act, expv, $time);
    end
  endtask

  // R6: every cycle compared against the one-edge-late model
  always @(negedge clk) if (rst_n && !finished) check(cur_req, seg, exp_seg);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_lit(int expect_lit, string req);
    int lit = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (seg != 7'b0) lit++;
    end
    checks++;
    if (lit != expect_lit) begin
      bad++;
      $display("FAIL %s: lit=%0d expected=%0d", req, lit, expect_lit);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    cur_req = "R7";
    check("R7", seg, 7'b0000000);
    rst_n = 1'b1;
    step(2);

    cur_req = "R5";
    for (int c = 0; c < 10; c++) begin bcd_in = 4'(c); step(1); end
    step(1);
    check("R5", seg, 7'b1110011);

    cur_req = "R4";
    for (int c = 10; c < 16; c++) begin bcd_in = 4'(c); step(1); end
    step(1);
    check("R4", seg, 7'b0000000);

    cur_req = "R3";
    bcd_in = 4'd3; step(1);
    hold = 1'b1; bcd_in = 4'd7; step(4);
    check("R3", seg, digit_shape(3));
    bcd_in = 4'd12; step(2);
    check("R3", seg, digit_shape(3));
    hold = 1'b0; step(2);
    check("R3", seg, 7'b0000000);

    cur_req = "R6";
    bcd_in = 4'd6; step(1);
    bcd_in = 4'd1; step(1);
    check("R6", seg, digit_shape(1));

    cur_req = "R2";
    blank_n = 1'b0; step(2);
    check("R2", seg, 7'b0000000);

    cur_req = "R1";
    lamp_test_n = 1'b0; bcd_in = 4'd14; step(2);
    check("R1", seg, 7'b1111111);
    blank_n = 1'b1; duty_we = 1'b1; duty_val = 8'd0; step(1);
    duty_we = 1'b0; step(3);
    check("R1", seg, 7'b1111111);
    lamp_test_n = 1'b1; bcd_in = 4'd8;

    cur_req = "R9";
    step(2);
    count_lit(0, "R9");

    cur_req = "R8";
    duty_we = 1'b1; duty_val = 8'd64; step(1);
    duty_we = 1'b0; step(2);
    count_lit(64, "R8");
    count_lit(64, "R8");

    cur_req = "R9";
    duty_we = 1'b1; duty_val = 8'd255; step(1);
    duty_we = 1'b0; step(2);
    count_lit(256, "R9");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule